// File: doc/BRIEF.md
# Interrupt Group Register Bank

This block holds the registers of one interrupt source group. Up to 32 event lines, each carrying single-cycle pulses, feed a latched identity register. An event is captured only when its mask bit is clear in the same cycle. A masked event is dropped for good; clearing the mask later does not recover it. Software reads and writes four 32-bit registers over a simple memory-mapped bus. The identity register is acknowledged by writing ones to the bits to clear.

A separate enable register decides which latched bits are reported. The block drives a pending vector, equal to identity AND enable, toward an upstream aggregator. That aggregator, message-based interrupt delivery and the event sources themselves are outside this block. A read-only status register gives software a view of the raw event lines, delayed by one register stage.

Top module: `irq_group_bank`

## Requirements
- R1: After reset the mask register is all ones, and the identity, enable and status registers and `pend_o` are all zeros.
- R2: An event pulse on line n sets identity bit n only if mask bit n is 0 in the cycle of the pulse. When mask bit n is 1, the pulse is discarded.
- R3: A write to the identity register clears each identity bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to the mask register or to the enable register replaces its whole value with the written data.
- R5: `pend_o` equals identity AND enable, bit by bit, and reflects the new register values in the cycle after any write or event capture.
- R6: Clearing a mask bit does not latch events that arrived while that bit was set.
- R7: If an event on an unmasked line and a write-one-to-clear of the same identity bit fall in the same cycle, the bit ends up set.
- R8: A read returns, one cycle later on `bus_rdata`, the register contents from before any same-cycle update. Reads change no register. `bus_rdata` holds its value in cycles with no read.
- R9: The status register returns the event lines as they were one cycle earlier. Writes to the status register have no effect.
- R10: The address is a byte offset. Bits [3:2] select the register: 0 is status, 1 is mask, 2 is identity and 3 is enable. An address with bits [1:0] nonzero, or with any bit above bit 3 set, selects no register: a write to it is ignored and a read of it returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulse lines, one per identity bit |
| bus_addr | input | 4 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read strobe |
| pend_o | output | 32 | Pending vector sent to the upstream aggregator (identity AND enable) |

## Verification
Two functions can act on the identity register in the same cycle: capture of an event pulse and a software write-one-to-clear. The bench provokes this by driving a pulse on one line in the same cycle as a write of all ones to the identity register. It then expects exactly that one bit to survive while every other bit is cleared. The same clock edge is also used to show that the mask in force before a mask write decides whether a pulse is captured. In a sweep over every bit, each line is unmasked alone and then cleared, and the result is compared against a mask-and-clear model kept in the bench.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

  // register select, taken from byte offset bits [3:2]
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_ID   = 2'd2,
    SEL_EN   = 2'd3
  } reg_sel_e;

  localparam int SEL_LSB = 2;
  localparam int SEL_W   = 2;

endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode
  import irq_grp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_mask,
  output logic              wr_id,
  output logic              wr_en,
  output logic              rd_hit,
  output reg_sel_e          sel
);

  localparam int TOP = SEL_LSB + SEL_W;

  logic hit;

  // valid means word aligned and nothing set above the select field
  function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
    logic ok;
    ok = (a[SEL_LSB-1:0] == '0);
    for (int i = TOP; i < ADDR_W; i++) begin
      if (a[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  always_comb begin
    hit = addr_ok(addr);
    sel = reg_sel_e'(addr[TOP-1:SEL_LSB]);
  end

  assign wr_mask = wr & hit & (sel == SEL_MASK);
  assign wr_id   = wr & hit & (sel == SEL_ID);
  assign wr_en   = wr & hit & (sel == SEL_EN);
  assign rd_hit  = rd & hit;

endmodule

// File: rtl/irq_grp_regs.sv
module irq_grp_regs #(
  parameter int N_EVT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             wr_mask,
  input  logic             wr_id,
  input  logic             wr_en,
  input  logic [N_EVT-1:0] wdata,
  output logic [N_EVT-1:0] mask_q,
  output logic [N_EVT-1:0] id_q,
  output logic [N_EVT-1:0] en_q,
  output logic [N_EVT-1:0] stat_q,
  output logic [N_EVT-1:0] cap_vec,
  output logic [N_EVT-1:0] clr_vec
);

  logic [N_EVT-1:0] id_nxt;

  // events that pass the mask currently in force
  function automatic logic [N_EVT-1:0] gate_evt(input logic [N_EVT-1:0] ev,
                                                input logic [N_EVT-1:0] mk);
    return ev & ~mk;
  endfunction

  // clear first, then capture, so a same-cycle event survives
  function automatic logic [N_EVT-1:0] id_step(input logic [N_EVT-1:0] cur,
                                               input logic [N_EVT-1:0] clr,
                                               input logic [N_EVT-1:0] cap);
    return (cur & ~clr) | cap;
  endfunction

  assign cap_vec = gate_evt(evt_i, mask_q);
  assign clr_vec = wr_id ? wdata : '0;
  assign id_nxt  = id_step(id_q, clr_vec, cap_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      id_q   <= '0;
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_en)   en_q   <= wdata;
      id_q   <= id_nxt;
      stat_q <= evt_i;
    end
  end

  // R2
  cap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vec != '0) |=> ((id_q & $past(cap_vec)) == $past(cap_vec)));

  // R2
  no_masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((id_q & ~$past(id_q) & ~$past(cap_vec)) == '0));

  // R3
  w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(id_q) & ~id_q & ~$past(clr_vec)) == '0));

  // R4
  mask_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wdata)));

  // R4
  en_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(wdata)));

  // R9
  stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q == $past(evt_i)));

endmodule

// File: rtl/irq_grp_rdmux.sv
module irq_grp_rdmux
  import irq_grp_pkg::*;
#(
  parameter int N_EVT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic             rd_hit,
  input  reg_sel_e         sel,
  input  logic [N_EVT-1:0] stat_q,
  input  logic [N_EVT-1:0] mask_q,
  input  logic [N_EVT-1:0] id_q,
  input  logic [N_EVT-1:0] en_q,
  output logic [N_EVT-1:0] rdata
);

  logic [N_EVT-1:0] pick;

  always_comb begin
    unique case (sel)
      SEL_STAT: pick = stat_q;
      SEL_MASK: pick = mask_q;
      SEL_ID:   pick = id_q;
      SEL_EN:   pick = en_q;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_hit) rdata <= pick;
    else if (rd)     rdata <= '0;
  end

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
  import irq_grp_pkg::*;
#(
  parameter int N_EVT  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [N_EVT-1:0]  bus_wdata,
  output logic [N_EVT-1:0]  bus_rdata,
  output logic [N_EVT-1:0]  pend_o
);

  logic             wr_mask, wr_id, wr_en, rd_hit;
  reg_sel_e         sel;
  logic [N_EVT-1:0] mask_q, id_q, en_q, stat_q;
  logic [N_EVT-1:0] cap_vec, clr_vec;

  irq_grp_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_mask(wr_mask), .wr_id(wr_id), .wr_en(wr_en),
    .rd_hit(rd_hit), .sel(sel)
  );

  irq_grp_regs #(.N_EVT(N_EVT)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .wr_mask(wr_mask), .wr_id(wr_id), .wr_en(wr_en), .wdata(bus_wdata),
    .mask_q(mask_q), .id_q(id_q), .en_q(en_q), .stat_q(stat_q),
    .cap_vec(cap_vec), .clr_vec(clr_vec)
  );

  irq_grp_rdmux #(.N_EVT(N_EVT)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .rd_hit(rd_hit), .sel(sel),
    .stat_q(stat_q), .mask_q(mask_q), .id_q(id_q), .en_q(en_q),
    .rdata(bus_rdata)
  );

  assign pend_o = id_q & en_q;

  // R7
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_id && ((cap_vec & bus_wdata) != '0)) |=>
      ((id_q & $past(cap_vec & bus_wdata)) == $past(cap_vec & bus_wdata)));

  // R10
  stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr[1:0] != 2'b00)) |=> $stable(mask_q) && $stable(en_q));

endmodule

// File: tb/sim_irq_group_bank.sv
`timescale 1ns/1ps
module sim_irq_group_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pend_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_STAT = 4'h0, A_MASK = 4'h4, A_ID = 4'h8, A_EN = 4'hC;

  always #2 clk = ~clk;

  irq_group_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pend_o(pend_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    logic [31:0] d, d2, m_id, m_en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_MASK, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(A_ID, d);   chk("R1 id", d, 32'h0);
    rd(A_EN, d);   chk("R1 en", d, 32'h0);
    rd(A_STAT, d); chk("R1 stat", d, 32'h0);
    chk("R1 pend", pend_o, 32'h0);

    // R2 masked events dropped, R6 unmask does not recover them
    pulse(32'hFFFF_FFFF);
    rd(A_ID, d); chk("R2 masked", d, 32'h0);
    wr(A_MASK, 32'h0);
    rd(A_ID, d); chk("R6 no retro", d, 32'h0);

    // R2/R3 sweep: unmask one line at a time, pulse all, then clear
    for (int n = 0; n < 32; n++) begin
      wr(A_MASK, ~(32'h1 << n));
      pulse(32'hFFFF_FFFF);
      rd(A_ID, d); chk("R2 sweep capture", d, 32'h1 << n);
      wr(A_ID, 32'h1 << n);
      rd(A_ID, d); chk("R3 sweep clear", d, 32'h0);
    end

    // R4 mask replace
    wr(A_MASK, 32'h1234_5678);
    rd(A_MASK, d); chk("R4 mask", d, 32'h1234_5678);

    // R3 partial clear
    wr(A_MASK, 32'h0);
    pulse(32'hFFFF_FFFF);
    m_id = 32'hFFFF_FFFF;
    wr(A_ID, 32'h0F0F_0F0F);
    m_id = m_id & ~32'h0F0F_0F0F;
    rd(A_ID, d); chk("R3 partial", d, m_id);

    // R4/R5 enable and pending
    m_en = 32'h00FF_00FF;
    wr(A_EN, m_en);
    chk("R5 pend after en", pend_o, m_id & m_en);
    rd(A_EN, d); chk("R4 en", d, m_en);
    m_en = 32'hFFFF_0000;
    wr(A_EN, m_en);
    chk("R5 pend en replace", pend_o, m_id & m_en);
    wr(A_ID, 32'hF000_0000);
    m_id = m_id & ~32'hF000_0000;
    chk("R5 pend after clear", pend_o, m_id & m_en);

    // R8 reads have no side effect
    rd(A_ID, d); rd(A_ID, d2);
    chk("R8 reread", d2, d);
    chk("R8 value", d, m_id);
    @(negedge clk); @(negedge clk);
    chk("R8 hold", bus_rdata, m_id);

    // R7 event and clear on the same bit in the same cycle
    @(negedge clk);
    evt_i = 32'h0000_0008;
    bus_addr = A_ID; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
    @(negedge clk);
    evt_i = '0; bus_wr = 1'b0;
    rd(A_ID, d); chk("R7 collide", d, 32'h0000_0008);
    wr(A_ID, 32'hFFFF_FFFF);

    // R2 old mask governs a pulse in the cycle of a mask write
    wr(A_MASK, 32'hFFFF_FFFF);
    @(negedge clk);
    evt_i = 32'h0000_0100;
    bus_addr = A_MASK; bus_wdata = 32'h0; bus_wr = 1'b1;
    @(negedge clk);
    evt_i = '0; bus_wr = 1'b0;
    rd(A_ID, d); chk("R2 old mask", d, 32'h0);

    // R9 status mirrors events, ignores writes
    wr(A_MASK, 32'hFFFF_FFFF);
    @(negedge clk);
    evt_i = 32'hA5A5_0F0F;
    rd(A_STAT, d);
    evt_i = '0;
    chk("R9 status", d, 32'hA5A5_0F0F);
    wr(A_STAT, 32'h1234_5678);
    rd(A_STAT, d); chk("R9 status write", d, 32'h0);

    // R10 unaligned and out-of-range addresses
    wr(4'h5, 32'h0000_0001);
    rd(A_MASK, d); chk("R10 stray write", d, 32'hFFFF_FFFF);
    rd(4'h6, d); chk("R10 stray read", d, 32'h0);
    wr(4'hD, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R10 stray en", d, 32'hFFFF_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule